// File: doc/BRIEF.md
# Priority Interrupt Presentation Controller

This block holds the presentation state for a small set of interrupt servers, one per processor. A source controller offers candidate interrupts, each naming a source number, a target server and an 8-bit priority, where a lower number means a more favoured interrupt. Each server keeps a single pending slot. A candidate either takes that slot, displacing a weaker occupant, or is turned away. Every interrupt that loses is handed back to the source controller as a reject pulse. Each server drives a level interrupt line to its processor. Each server also has its own inter-processor interrupt source, which is raised by writing a request priority.

Processors act on their server through four operations: accept, end-of-interrupt, set the current priority, and set the inter-processor request priority. Each server has a 32-bit state word. Bits 31:24 hold the current processor priority. Bits 23:0 hold the pending source number, where zero means nothing is pending.

Both input channels use valid/ready. The operation channel is always ready. The source channel is back-pressured in any cycle in which an operation is offered, so at most one event is taken per cycle. Result pulses (reject, EOI, resend, read data, error) cannot be stalled. They appear in the cycle after the event that caused them and last exactly one cycle.

Top module: `pic_presenter`

## Requirements
- R1: After reset every interrupt line is low, every state word reads 0x00000000, every request priority is 0xFF and no pulse is driven.
- R2: A source request whose priority is strictly below the server's current priority, while no pending interrupt has priority less than or equal to it, becomes pending and raises that server's line in the next cycle.
- R3: A source request is rejected, with its number on the reject pulse and no state change, if its priority is not below the current priority or if a pending interrupt has priority less than or equal to it. A request carrying source number 0 is dropped with no pulse.
- R4: A source request that wins while another interrupt is pending displaces it. The displaced source number is rejected, and the line stays high.
- R5: A request-priority write (op code 3, value in op_data[7:0]) acts only if the value is below the current priority and no pending interrupt has priority less than or equal to it. In that case any pending interrupt is rejected, source 2 becomes pending at that priority, and the line is raised. Otherwise only the stored value changes.
- R6: Accept (op code 0) returns the whole state word on the read port one cycle later and lowers the line. The word then becomes the last pending priority in bits 31:24 with the source field zero.
- R7: End-of-interrupt (op code 1) emits op_data[23:0] on the EOI pulse and loads op_data[31:24] as the current priority. If nothing is pending, it performs a resend.
- R8: A current-priority write (op code 2, value in op_data[7:0]) that lowers the value, while a pending interrupt has priority at or above the new value, clears the pending source, lowers the line and rejects that source.
- R9: A current-priority write that does not lower the value, while nothing is pending, performs a resend.
- R10: A resend first re-runs the inter-processor check of R5 if the request priority is below the current priority. It then emits a resend pulse.
- R11: An operation naming a server index at or beyond the server count raises op_err and changes nothing. A source request aimed at such an index is rejected.
- R12: When both channels are valid, the operation is taken and src_ready is low. A cycle with no accepted event produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source request offered |
| src_ready | output | 1 | Source request taken this cycle |
| src_num | input | 24 | Source number |
| src_server | input | SEL_W | Target server index |
| src_prio | input | 8 | Source priority |
| op_valid | input | 1 | Processor operation offered |
| op_ready | output | 1 | Always high |
| op_kind | input | 2 | 0 accept, 1 EOI, 2 set priority, 3 set request priority |
| op_server | input | SEL_W | Server the operation acts on |
| op_data | input | 32 | Operation word |
| rd_valid | output | 1 | Accept result pulse |
| rd_data | output | 32 | State word returned by accept |
| op_err | output | 1 | Server index out of range |
| rej_valid | output | 1 | Reject pulse |
| rej_num | output | 24 | Rejected source number |
| eoi_valid | output | 1 | EOI pulse to the source controller |
| eoi_num | output | 24 | Source number being retired |
| resend_valid | output | 1 | Request to resend rejected sources |
| cpu_irq | output | NSRV | Interrupt line per server |

## Verification
A corrupted current priority shows up at the ports in two ways. The next source request is accepted or rejected against the wrong threshold, and an accept returns the wrong bits 31:24; either appears one cycle after the event. A stale pending priority escapes through the priority that an accept loads, and it shows on the following accept. A lost request priority only shows when a later resend or priority write should raise source 2 and does not. The sequence therefore walks a server through deliver, displace, accept, EOI, priority changes and inter-processor requests, so that each stored field is read back through the ports.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_SRC    = 24'd2;
  localparam logic [PRIO_W-1:0] PRIO_LEAST = 8'hFF;

  typedef enum logic [1:0] {
    OP_ACCEPT = 2'd0,
    OP_EOI    = 2'd1,
    OP_CPPR   = 2'd2,
    OP_MFRR   = 2'd3
  } op_e;

  typedef struct packed {
    logic             valid;
    logic [SRC_W-1:0] num;
  } srcmsg_t;

  typedef struct packed {
    srcmsg_t           rej;
    srcmsg_t           eoi;
    logic              resend;
    logic              rd;
    logic [WORD_W-1:0] rdata;
  } srv_fx_t;
endpackage

// File: rtl/pic_server.sv
module pic_server
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_req,
  input  logic [SRC_W-1:0]  in_num,
  input  logic [PRIO_W-1:0] in_prio,
  input  logic              op_en,
  input  op_e               op_kind,
  input  logic [WORD_W-1:0] op_word,
  output logic              irq,
  output srv_fx_t           fx
);
  logic [PRIO_W-1:0] cppr_q, cppr_n, pend_q, pend_n, mfrr_q, mfrr_n;
  logic [SRC_W-1:0]  xisr_q, xisr_n;
  logic              irq_q, irq_n;
  logic              do_resend, ipi_chk;
  logic [PRIO_W-1:0] wprio;

  assign wprio = op_word[PRIO_W-1:0];

  always_comb begin
    cppr_n    = cppr_q;
    xisr_n    = xisr_q;
    pend_n    = pend_q;
    mfrr_n    = mfrr_q;
    irq_n     = irq_q;
    fx        = '0;
    do_resend = 1'b0;
    ipi_chk   = 1'b0;
    if (in_req) begin
      if (in_prio >= cppr_q || (xisr_q != '0 && pend_q <= in_prio)) begin
        fx.rej.valid = 1'b1;
        fx.rej.num   = in_num;
      end else begin
        if (xisr_q != '0) begin
          fx.rej.valid = 1'b1;
          fx.rej.num   = xisr_q;
        end
        xisr_n = in_num;
        pend_n = in_prio;
        irq_n  = 1'b1;
      end
    end else if (op_en) begin
      case (op_kind)
        OP_ACCEPT: begin
          irq_n    = 1'b0;
          fx.rd    = 1'b1;
          fx.rdata = {cppr_q, xisr_q};
          cppr_n   = pend_q;
          xisr_n   = '0;
        end
        OP_EOI: begin
          fx.eoi.valid = 1'b1;
          fx.eoi.num   = op_word[SRC_W-1:0];
          cppr_n       = op_word[WORD_W-1:SRC_W];
          if (xisr_q == '0) do_resend = 1'b1;
        end
        OP_CPPR: begin
          cppr_n = wprio;
          if (wprio < cppr_q) begin
            if (xisr_q != '0 && wprio <= pend_q) begin
              xisr_n       = '0;
              irq_n        = 1'b0;
              fx.rej.valid = 1'b1;
              fx.rej.num   = xisr_q;
            end
          end else if (xisr_q == '0) begin
            do_resend = 1'b1;
          end
        end
        default: begin
          mfrr_n = wprio;
          if (wprio < cppr_q) ipi_chk = 1'b1;
        end
      endcase
    end
    if (do_resend) begin
      fx.resend = 1'b1;
      if (mfrr_n < cppr_n) ipi_chk = 1'b1;
    end
    if (ipi_chk && !(xisr_n != '0 && pend_n <= mfrr_n)) begin
      if (xisr_n != '0) begin
        fx.rej.valid = 1'b1;
        fx.rej.num   = xisr_n;
      end
      xisr_n = IPI_SRC;
      pend_n = mfrr_n;
      irq_n  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cppr_q <= '0;
      xisr_q <= '0;
      pend_q <= '0;
      mfrr_q <= PRIO_LEAST;
      irq_q  <= 1'b0;
    end else begin
      cppr_q <= cppr_n;
      xisr_q <= xisr_n;
      pend_q <= pend_n;
      mfrr_q <= mfrr_n;
      irq_q  <= irq_n;
    end
  end

  assign irq = irq_q;

  AST_LINE_TRACKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (xisr_q != '0)); // R2
  AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && !in_req && op_kind == OP_ACCEPT) |=> !irq_q); // R6
  AST_WIN_RAISES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && in_prio < cppr_q && (xisr_q == '0 || in_prio < pend_q)) |=> irq_q); // R2
endmodule

// File: rtl/pic_fx_merge.sv
module pic_fx_merge
  import pic_pkg::*;
#(
  parameter int NSRV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  srv_fx_t          fx_in [NSRV],
  input  logic             bad_rej,
  input  logic [SRC_W-1:0] bad_num,
  output srv_fx_t          fx_out
);
  logic [NSRV-1:0] act;

  for (genvar g = 0; g < NSRV; g++) begin : g_act
    assign act[g] = fx_in[g].rej.valid | fx_in[g].eoi.valid | fx_in[g].resend | fx_in[g].rd;
  end

  always_comb begin
    fx_out = '0;
    for (int i = 0; i < NSRV; i++) fx_out = srv_fx_t'(fx_out | fx_in[i]);
    if (bad_rej) begin
      fx_out.rej.valid = 1'b1;
      fx_out.rej.num   = bad_num;
    end
  end

  AST_ONE_SERVER_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act, bad_rej})); // R12
endmodule

// File: rtl/pic_presenter.sv
module pic_presenter
  import pic_pkg::*;
#(
  parameter int NSRV  = 4,
  parameter int SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [SRC_W-1:0]  src_num,
  input  logic [SEL_W-1:0]  src_server,
  input  logic [PRIO_W-1:0] src_prio,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_kind,
  input  logic [SEL_W-1:0]  op_server,
  input  logic [WORD_W-1:0] op_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              op_err,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_num,
  output logic              eoi_valid,
  output logic [SRC_W-1:0]  eoi_num,
  output logic              resend_valid,
  output logic [NSRV-1:0]   cpu_irq
);
  localparam logic [SEL_W-1:0] SRV_LIMIT = SEL_W'(NSRV);

  logic    op_fire, src_fire, op_ok, src_ok;
  op_e     kind;
  srv_fx_t fx_each [NSRV];
  srv_fx_t fx_all;

  assign op_ready  = 1'b1;
  assign src_ready = !op_valid;
  assign op_fire   = op_valid;
  assign src_fire  = src_valid && !op_valid;
  assign op_ok     = op_server < SRV_LIMIT;
  assign src_ok    = src_server < SRV_LIMIT;
  assign kind      = op_e'(op_kind);

  for (genvar g = 0; g < NSRV; g++) begin : g_srv
    logic hit_src, hit_op;
    assign hit_src = src_fire && src_ok && src_server == SEL_W'(g) && src_num != '0;
    assign hit_op  = op_fire && op_ok && op_server == SEL_W'(g);
    pic_server u_srv (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_req  (hit_src),
      .in_num  (src_num),
      .in_prio (src_prio),
      .op_en   (hit_op),
      .op_kind (kind),
      .op_word (op_data),
      .irq     (cpu_irq[g]),
      .fx      (fx_each[g])
    );
  end

  pic_fx_merge #(.NSRV(NSRV)) u_merge (
    .clk     (clk),
    .rst_n   (rst_n),
    .fx_in   (fx_each),
    .bad_rej (src_fire && !src_ok),
    .bad_num (src_num),
    .fx_out  (fx_all)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      op_err       <= 1'b0;
      rej_valid    <= 1'b0;
      rej_num      <= '0;
      eoi_valid    <= 1'b0;
      eoi_num      <= '0;
      resend_valid <= 1'b0;
    end else begin
      rd_valid     <= fx_all.rd;
      rd_data      <= fx_all.rdata;
      op_err       <= op_fire && !op_ok;
      rej_valid    <= fx_all.rej.valid;
      rej_num      <= fx_all.rej.num;
      eoi_valid    <= fx_all.eoi.valid;
      eoi_num      <= fx_all.eoi.num;
      resend_valid <= fx_all.resend;
    end
  end

  AST_QUIET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_fire || src_fire) |=> !(rej_valid || eoi_valid || resend_valid || rd_valid)); // R12
  AST_READ_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_fire && op_ok && kind == OP_ACCEPT) |=> !rd_valid); // R6
  AST_ERR_IS_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !(rd_valid || rej_valid || eoi_valid || resend_valid)); // R11
endmodule

// File: tb/tb_pic_presenter.sv
module tb_pic_presenter;
  localparam int CLK_P = 10;
  localparam int NSRV  = 4;
  localparam int SEL_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_valid = 1'b0, op_valid = 1'b0;
  logic [23:0] src_num = '0;
  logic [SEL_W-1:0] src_server = '0, op_server = '0;
  logic [7:0] src_prio = '0;
  logic [1:0] op_kind = '0;
  logic [31:0] op_data = '0;
  logic src_ready, op_ready, rd_valid, op_err, rej_valid, eoi_valid, resend_valid;
  logic [31:0] rd_data;
  logic [23:0] rej_num, eoi_num;
  logic [NSRV-1:0] cpu_irq;

  int checks = 0, failures = 0;
  bit finished = 0;

  typedef struct {
    string tag;
    logic rej; logic [23:0] rn;
    logic eoi; logic [23:0] en;
    logic rs; logic rd; logic [31:0] rdd;
    logic err; logic [3:0] irq;
  } exp_t;
  exp_t exq[$];

  always #(CLK_P/2) clk = ~clk;

  pic_presenter #(.NSRV(NSRV), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .src_valid(src_valid), .src_ready(src_ready), .src_num(src_num),
    .src_server(src_server), .src_prio(src_prio),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_server(op_server), .op_data(op_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .op_err(op_err),
    .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend_valid(resend_valid), .cpu_irq(cpu_irq)
  );

  task automatic expect_out(string tag, logic rej, logic [23:0] rn, logic eoi, logic [23:0] en,
                            logic rs, logic rd, logic [31:0] rdd, logic err, logic [3:0] irq);
    exp_t e;
    e.tag = tag; e.rej = rej; e.rn = rn; e.eoi = eoi; e.en = en;
    e.rs = rs; e.rd = rd; e.rdd = rdd; e.err = err; e.irq = irq;
    exq.push_back(e);
  endtask

  task automatic drv_src(logic [SEL_W-1:0] srv, logic [23:0] num, logic [7:0] prio);
    @(negedge clk);
    op_valid = 1'b0; src_valid = 1'b1;
    src_server = srv; src_num = num; src_prio = prio;
  endtask

  task automatic drv_op(logic [1:0] kind, logic [SEL_W-1:0] srv, logic [31:0] data);
    @(negedge clk);
    src_valid = 1'b0; op_valid = 1'b1;
    op_kind = kind; op_server = srv; op_data = data;
  endtask

  task automatic drv_idle();
    @(negedge clk);
    src_valid = 1'b0; op_valid = 1'b0;
  endtask

  // Monitor: pops one expectation per clock edge that had one queued
  initial begin
    exp_t e;
    bit bad;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exq.size() != 0) begin
        e = exq.pop_front();
        checks++;
        bad = (rej_valid !== e.rej) || (e.rej && rej_num !== e.rn) ||
              (eoi_valid !== e.eoi) || (e.eoi && eoi_num !== e.en) ||
              (resend_valid !== e.rs) || (rd_valid !== e.rd) ||
              (e.rd && rd_data !== e.rdd) || (op_err !== e.err) || (cpu_irq !== e.irq);
        if (bad) begin
          failures++;
          $display("FAIL %s: got rej=%0b/%h eoi=%0b/%h rs=%0b rd=%0b/%h err=%0b irq=%b exp rej=%0b/%h eoi=%0b/%h rs=%0b rd=%0b/%h err=%0b irq=%b",
                   e.tag, rej_valid, rej_num, eoi_valid, eoi_num, resend_valid, rd_valid, rd_data,
                   op_err, cpu_irq, e.rej, e.rn, e.eoi, e.en, e.rs, e.rd, e.rdd, e.err, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (cpu_irq !== 4'b0 || rej_valid || rd_valid || resend_valid || eoi_valid || op_err) begin
      failures++;
      $display("FAIL R1: got irq=%b pulses present expected all quiet", cpu_irq);
    end
    drv_op(2'd0, 0, 32'h0);          expect_out("R1 accept after reset", 0,0,0,0,0,1,32'h0000_0000,0,4'b0000);
    drv_op(2'd2, 0, 32'h80);         expect_out("R9 raise prio resend", 0,0,0,0,1,0,0,0,4'b0000);
    drv_src(0, 24'h100, 8'h40);      expect_out("R2 deliver", 0,0,0,0,0,0,0,0,4'b0001);
    drv_src(0, 24'h101, 8'h40);      expect_out("R3 equal to pending", 1,24'h101,0,0,0,0,0,0,4'b0001);
    drv_src(0, 24'h102, 8'h90);      expect_out("R3 above current prio", 1,24'h102,0,0,0,0,0,0,4'b0001);
    drv_src(0, 24'h103, 8'h20);      expect_out("R4 preempt", 1,24'h100,0,0,0,0,0,0,4'b0001);
    drv_op(2'd0, 0, 32'h0);          expect_out("R6 accept word", 0,0,0,0,0,1,32'h8000_0103,0,4'b0000);
    drv_op(2'd0, 0, 32'h0);          expect_out("R6 source cleared", 0,0,0,0,0,1,32'h2000_0000,0,4'b0000);
    drv_op(2'd1, 0, 32'h8000_0103);  expect_out("R7 eoi resend", 0,0,1,24'h103,1,0,0,0,4'b0000);
    drv_op(2'd3, 0, 32'h90);         expect_out("R5 request not below", 0,0,0,0,0,0,0,0,4'b0000);
    drv_src(0, 24'h104, 8'h50);      expect_out("R2 deliver second", 0,0,0,0,0,0,0,0,4'b0001);
    drv_op(2'd3, 0, 32'h60);         expect_out("R5 pending wins", 0,0,0,0,0,0,0,0,4'b0001);
    drv_op(2'd3, 0, 32'h30);         expect_out("R5 ipi displaces", 1,24'h104,0,0,0,0,0,0,4'b0001);
    drv_op(2'd0, 0, 32'h0);          expect_out("R5 ipi source 2", 0,0,0,0,0,1,32'h8000_0002,0,4'b0000);
    drv_op(2'd1, 0, 32'h7000_0002);  expect_out("R10 eoi ipi recheck", 0,0,1,24'h2,1,0,0,0,4'b0001);
    drv_op(2'd2, 0, 32'h20);         expect_out("R8 lower clears", 1,24'h2,0,0,0,0,0,0,4'b0000);
    drv_op(2'd0, 0, 32'h0);          expect_out("R6 empty accept", 0,0,0,0,0,1,32'h2000_0000,0,4'b0000);
    drv_op(2'd2, 0, 32'h60);         expect_out("R10 resend ipi", 0,0,0,0,1,0,0,0,4'b0001);
    drv_src(1, 24'h1FF, 8'h10);      expect_out("R3 server1 prio zero", 1,24'h1FF,0,0,0,0,0,0,4'b0001);
    drv_op(2'd2, 1, 32'hFF);         expect_out("R9 server1 resend", 0,0,0,0,1,0,0,0,4'b0001);
    drv_src(1, 24'h200, 8'h10);      expect_out("R2 server1 deliver", 0,0,0,0,0,0,0,0,4'b0011);
    drv_op(2'd3, 5, 32'h01);         expect_out("R11 bad op server", 0,0,0,0,0,0,0,1,4'b0011);
    drv_src(6, 24'h300, 8'h01);      expect_out("R11 bad src server", 1,24'h300,0,0,0,0,0,0,4'b0011);
    drv_src(2, 24'h0, 8'h01);        expect_out("R3 source zero dropped", 0,0,0,0,0,0,0,0,4'b0011);
    @(negedge clk);
    src_valid = 1'b1; src_server = 1; src_num = 24'h201; src_prio = 8'h05;
    op_valid = 1'b1; op_kind = 2'd0; op_server = 1; op_data = 32'h0;
    expect_out("R12 op wins", 0,0,0,0,0,1,32'hFF00_0200,0,4'b0001);
    #1;
    checks++;
    if (src_ready !== 1'b0 || op_ready !== 1'b1) begin
      failures++;
      $display("FAIL R12: got src_ready=%0b op_ready=%0b expected 0 1", src_ready, op_ready);
    end
    drv_src(1, 24'h201, 8'h05);      expect_out("R12 held source taken", 0,0,0,0,0,0,0,0,4'b0011);
    drv_op(2'd0, 1, 32'h0);          expect_out("R6 prio from pending", 0,0,0,0,0,1,32'h1000_0201,0,4'b0001);
    drv_op(2'd2, 0, 32'h10);         expect_out("R8 lower rejects ipi", 1,24'h2,0,0,0,0,0,0,4'b0000);
    drv_idle();                      expect_out("R12 idle quiet", 0,0,0,0,0,0,0,0,4'b0000);
    drv_idle();
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule